// File: doc/BRIEF.md
# Counter Overflow Interrupt Enable Unit

This block turns overflow pulses from a group of event counters and one cycle counter into two active-low interrupt requests: a normal request and a fast request. Each overflow pulse sets a sticky per-source flag. Each request has its own enable mask. A request output is driven low while at least one flagged source is enabled in that output's mask.

Software reaches the block through a small coprocessor-style register bus. Each enable mask has a set view and a clear view. Writing ones to the set view enables sources, and writing ones to the clear view disables them. Reading either view returns the mask. A status register reports the sticky flags, and writing ones to it clears them. Privileged accesses always proceed. A user-mode access proceeds only when the user-access enable input is high. A refused access raises a one-cycle error and changes nothing.

Top module: `ovf_irq_unit`

## Requirements
- R1: After a synchronous reset, all enable bits and flags are zero, both request outputs are high, `bus_rdata` is zero and `bus_err` is low.
- R2: The source bit layout is the same in every register. Bit 31 is the cycle counter, and bits 2, 1 and 0 are event counters 2, 1 and 0. The `ovf_pulse` input uses bit 3 for the cycle counter and bits 2..0 for event counters 2..0. Bits 30..3 always read as zero, and writes to them are ignored.
- R3: Addresses 0 (normal set view) and 2 (fast set view): each 1 written enables that source in the matching mask, and each 0 written leaves that bit unchanged.
- R4: Addresses 1 (normal clear view) and 3 (fast clear view): each 1 written disables that source in the matching mask, and each 0 written leaves that bit unchanged. An enable bit falls only through such a write or through reset.
- R5: An accepted read of address 0 or 1 returns the normal mask, and an accepted read of address 2 or 3 returns the fast mask. `bus_rdata` is registered: it takes the value one clock after the read is accepted and holds it until the next accepted read.
- R6: An overflow pulse sets its source's sticky flag. Address 4 reads the flags, and writing ones to address 4 clears those flags. When a pulse and a clear for the same source fall in the same cycle, the flag stays set.
- R7: `irq_norm_n` is registered. It is low one clock after the cycle in which any flag is set together with its normal enable bit, and high otherwise.
- R8: `irq_fast_n` follows the same rule as R7, using the independent fast mask.
- R9: An access is accepted when `bus_priv` is 1 or `user_access_en` is 1. A refused access drives `bus_err` high for exactly the following cycle. It changes no mask, no flag and no `bus_rdata`.
- R10: Addresses 5 to 7 are unmapped. Reads from them return zero, writes to them have no effect, and neither raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| user_access_en | input | 1 | Allows user-mode accesses |
| ovf_pulse | input | 4 | Overflow pulses: bit 3 cycle counter, bits 2..0 event counters |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle access-refused response |
| irq_norm_n | output | 1 | Active-low normal interrupt request |
| irq_fast_n | output | 1 | Active-low fast interrupt request |

## Verification
Directed cases come first:
- all-ones writes, which separate the four live bits from the reserved ones;
- zero writes to each view, which show that a zero has no effect;
- a pulse and a status clear for the same source in one cycle, which exposes the wrong priority;
- user-mode accesses with the enable low, which show that a refused access leaves the masks and read data untouched.

After these, seeded random traffic mixes privilege levels, all eight addresses and sparse overflow pulses. The bench compares both request outputs every cycle. The normal and fast outputs are driven from different masks, so a swap or a shared mask shows up at once. Unmapped-address traffic separates correct decoding from aliasing onto a live register.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_EVT = 3;
    localparam int CYC_BIT = 31;
    localparam int NSRC    = NUM_EVT + 1;
    localparam int ADDR_W  = 3;
    localparam int NUM_REQ = 2;   // 0: normal, 1: fast

    localparam logic [ADDR_W-1:0] ADR_NSET = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_NCLR = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_FSET = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_FCLR = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;

    typedef logic [NSRC-1:0]   src_vec_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_NORM,
        SEL_FAST,
        SEL_STAT
    } rd_sel_e;

    typedef struct packed {
        logic [NUM_REQ-1:0] set_we;
        logic [NUM_REQ-1:0] clr_we;
        logic               stat_we;
        logic               rd_en;
        rd_sel_e            rd_sel;
        logic               deny;
    } bus_cmd_t;

    // Spread a compact source vector onto the register bit layout.
    function automatic word_t to_word(input src_vec_t s);
        word_t w;
        w = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            w[i] = s[i];
        end
        w[CYC_BIT] = s[NUM_EVT];
        return w;
    endfunction

    // Gather the live bits of a register word; reserved bits drop out.
    function automatic src_vec_t to_src(input word_t w);
        src_vec_t s;
        for (int i = 0; i < NUM_EVT; i++) begin
            s[i] = w[i];
        end
        s[NUM_EVT] = w[CYC_BIT];
        return s;
    endfunction

endpackage

// File: rtl/ovf_bus_decode.sv
module ovf_bus_decode
    import ovf_irq_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic              priv,
    input  logic              user_en,
    output bus_cmd_t          cmd
);

    logic allowed;

    assign allowed = priv | user_en;

    always_comb begin
        cmd = '0;
        cmd.rd_sel = SEL_NONE;
        if (valid) begin
            if (!allowed) begin
                cmd.deny = 1'b1;
            end else if (write) begin
                for (int r = 0; r < NUM_REQ; r++) begin
                    cmd.set_we[r] = (addr == ADDR_W'(2 * r));
                    cmd.clr_we[r] = (addr == ADDR_W'(2 * r + 1));
                end
                cmd.stat_we = (addr == ADR_STAT);
            end else begin
                cmd.rd_en = 1'b1;
                case (addr)
                    ADR_NSET, ADR_NCLR: cmd.rd_sel = SEL_NORM;
                    ADR_FSET, ADR_FCLR: cmd.rd_sel = SEL_FAST;
                    ADR_STAT:           cmd.rd_sel = SEL_STAT;
                    default:            cmd.rd_sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/ovf_enable_mask.sv
module ovf_enable_mask
    import ovf_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     set_we,
    input  logic     clr_we,
    input  src_vec_t bits,
    output src_vec_t mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (set_we) begin
            mask <= mask | bits;
        end else if (clr_we) begin
            mask <= mask & ~bits;
        end
    end

endmodule

// File: rtl/ovf_status_flags.sv
module ovf_status_flags
    import ovf_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pulse,
    input  logic     clr_we,
    input  src_vec_t bits,
    output src_vec_t flags
);

    src_vec_t clr_bits;

    assign clr_bits = clr_we ? bits : '0;

    // A fresh pulse wins over a clear landing in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_bits) | pulse;
        end
    end

endmodule

// File: rtl/ovf_req_drive.sv
module ovf_req_drive
    import ovf_irq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  src_vec_t               flags,
    input  src_vec_t [NUM_REQ-1:0] masks,
    output logic [NUM_REQ-1:0]     req_n
);

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst) begin
                req_n[g] <= 1'b1;
            end else begin
                req_n[g] <= ~|(flags & masks[g]);
            end
        end
    end

endmodule

// File: rtl/ovf_irq_unit.sv
module ovf_irq_unit
    import ovf_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_priv,
    input  logic              user_access_en,
    input  logic [NSRC-1:0]   ovf_pulse,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              irq_norm_n,
    output logic              irq_fast_n
);

    bus_cmd_t               cmd;
    src_vec_t               wbits;
    src_vec_t [NUM_REQ-1:0] en_mask;
    src_vec_t               flags;
    logic [NUM_REQ-1:0]     req_n;
    word_t                  rd_word;

    assign wbits = to_src(bus_wdata);

    ovf_bus_decode u_dec (
        .valid   (bus_valid),
        .write   (bus_write),
        .addr    (bus_addr),
        .priv    (bus_priv),
        .user_en (user_access_en),
        .cmd     (cmd)
    );

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_mask
        ovf_enable_mask u_mask (
            .clk    (clk),
            .rst    (rst),
            .set_we (cmd.set_we[g]),
            .clr_we (cmd.clr_we[g]),
            .bits   (wbits),
            .mask   (en_mask[g])
        );
    end

    ovf_status_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .pulse  (ovf_pulse),
        .clr_we (cmd.stat_we),
        .bits   (wbits),
        .flags  (flags)
    );

    ovf_req_drive u_req (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .masks (en_mask),
        .req_n (req_n)
    );

    assign irq_norm_n = req_n[0];
    assign irq_fast_n = req_n[1];

    always_comb begin
        case (cmd.rd_sel)
            SEL_NORM: rd_word = to_word(en_mask[0]);
            SEL_FAST: rd_word = to_word(en_mask[1]);
            SEL_STAT: rd_word = to_word(flags);
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= cmd.deny;
            if (cmd.rd_en) begin
                bus_rdata <= rd_word;
            end
        end
    end

endmodule

// File: rtl/ovf_irq_checker.sv
module ovf_irq_checker
    import ovf_irq_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_valid,
    input logic                   bus_write,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_priv,
    input logic                   user_access_en,
    input logic [NSRC-1:0]        ovf_pulse,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic                   bus_err,
    input logic                   irq_norm_n,
    input logic                   irq_fast_n,
    input src_vec_t [NUM_REQ-1:0] en_mask,
    input src_vec_t               flags
);

    logic past_ok;
    logic refused;
    logic accepted_wr;

    assign refused     = bus_valid && !bus_priv && !user_access_en;
    assign accepted_wr = bus_valid && bus_write && (bus_priv || user_access_en);

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[CYC_BIT-1:NUM_EVT] == '0); // R2

    AST_NORM_REQ: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (irq_norm_n == !$past(|(flags & en_mask[0])))); // R7

    AST_FAST_REQ: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (irq_fast_n == !$past(|(flags & en_mask[1])))); // R8

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && bus_err) |-> $past(refused)); // R9

    AST_REFUSED_HOLD: assert property (@(posedge clk) disable iff (rst)
        refused |=> ($stable(en_mask) && $stable(bus_rdata) && bus_err)); // R9

    AST_NORM_FALL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (past_ok && (($past(en_mask[0]) & ~en_mask[0]) != '0))
            |-> $past(accepted_wr && bus_addr == ADR_NCLR)); // R4

    AST_FAST_FALL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (past_ok && (($past(en_mask[1]) & ~en_mask[1]) != '0))
            |-> $past(accepted_wr && bus_addr == ADR_FCLR)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (past_ok && (($past(flags) & ~flags) != '0))
            |-> $past(accepted_wr && bus_addr == ADR_STAT)); // R6

    AST_PULSE_SETS: assert property (@(posedge clk) disable iff (rst)
        (ovf_pulse != '0) |=> ((flags & $past(ovf_pulse)) == $past(ovf_pulse))); // R6

endmodule

bind ovf_irq_unit ovf_irq_checker u_chk (.*);

// File: tb/tb_ovf_irq_unit.sv
`timescale 1ns/1ps
module tb_ovf_irq_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_priv = 1'b0;
    logic        user_access_en = 1'b0;
    logic [3:0]  ovf_pulse = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_norm_n;
    logic        irq_fast_n;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    // Reference state
    logic [3:0]  m_en_n = '0;
    logic [3:0]  m_en_f = '0;
    logic [3:0]  m_flg  = '0;
    logic [31:0] m_rdata = '0;

    always #4 clk = ~clk;

    ovf_irq_unit dut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_priv(bus_priv), .user_access_en(user_access_en),
        .ovf_pulse(ovf_pulse), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq_norm_n(irq_norm_n), .irq_fast_n(irq_fast_n)
    );

    function automatic logic [31:0] b_word(input logic [3:0] s);
        return {s[3], 28'd0, s[2:0]};
    endfunction

    function automatic logic [3:0] b_src(input logic [31:0] w);
        return {w[31], w[2:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, model the rising edge, compare at the next falling edge.
    task automatic step(input logic v, input logic w, input logic [2:0] a,
                        input logic pr, input logic ue, input logic [31:0] wd,
                        input logic [3:0] p, input string tag);
        logic ok;
        logic [3:0] u;
        logic exp_n, exp_f, exp_e;
        bus_valid = v; bus_write = w; bus_addr = a; bus_priv = pr;
        user_access_en = ue; bus_wdata = wd; ovf_pulse = p;
        @(posedge clk);
        ok    = pr | ue;
        u     = b_src(wd);
        exp_n = ~|(m_flg & m_en_n);
        exp_f = ~|(m_flg & m_en_f);
        exp_e = v & ~ok;
        if (v && ok && !w) begin
            case (a)
                3'd0, 3'd1: m_rdata = b_word(m_en_n);
                3'd2, 3'd3: m_rdata = b_word(m_en_f);
                3'd4:       m_rdata = b_word(m_flg);
                default:    m_rdata = 32'd0;
            endcase
        end
        if (v && ok && w) begin
            case (a)
                3'd0: m_en_n = m_en_n | u;
                3'd1: m_en_n = m_en_n & ~u;
                3'd2: m_en_f = m_en_f | u;
                3'd3: m_en_f = m_en_f & ~u;
                3'd4: m_flg  = m_flg & ~u;
                default: ;
            endcase
        end
        m_flg = m_flg | p;
        @(negedge clk);
        chk("R7 irq_norm_n", {31'd0, irq_norm_n}, {31'd0, exp_n});
        chk("R8 irq_fast_n", {31'd0, irq_fast_n}, {31'd0, exp_f});
        chk("R9 bus_err",    {31'd0, bus_err},    {31'd0, exp_e});
        chk(tag, bus_rdata, m_rdata);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 32'd0, 4'd0, "idle");
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 irq_norm_n", {31'd0, irq_norm_n}, 32'd1);
        chk("R1 irq_fast_n", {31'd0, irq_fast_n}, 32'd1);
        chk("R1 bus_rdata",  bus_rdata, 32'd0);
        chk("R1 bus_err",    {31'd0, bus_err}, 32'd0);
        step(1'b1, 1'b0, 3'd4, 1'b1, 1'b0, 32'd0, 4'd0, "R1 status after reset");

        // R2: all ones into the normal set view, reserved bits ignored
        step(1'b1, 1'b1, 3'd0, 1'b1, 1'b0, 32'hFFFF_FFFF, 4'd0, "R2 write");
        step(1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 32'd0, 4'd0, "R2 layout readback");
        chk("R2 value", bus_rdata, 32'h8000_0007);

        // R3: set view, zeros have no effect
        step(1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 32'h0000_0002, 4'd0, "R3 set");
        step(1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 32'h0000_0000, 4'd0, "R3 zero set");
        step(1'b1, 1'b0, 3'd2, 1'b1, 1'b0, 32'd0, 4'd0, "R3 readback");
        chk("R3 value", bus_rdata, 32'h0000_0002);

        // R4 / R5: clear view, read through the clear address
        step(1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 32'h0000_0001, 4'd0, "R4 clear");
        step(1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 32'h0000_0000, 4'd0, "R4 zero clear");
        step(1'b1, 1'b0, 3'd1, 1'b1, 1'b0, 32'd0, 4'd0, "R5 clear-view read");
        chk("R4 value", bus_rdata, 32'h8000_0006);

        // R6 / R7 / R8: overflow flags drive the requests
        step(1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 32'd0, 4'b0001, "R6 pulse src0");
        idle();
        chk("R7 src0 not enabled", {31'd0, irq_norm_n}, 32'd1);
        step(1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 32'd0, 4'b0010, "R6 pulse src1");
        idle();
        chk("R8 fast low", {31'd0, irq_fast_n}, 32'd0);
        step(1'b1, 1'b0, 3'd4, 1'b1, 1'b0, 32'd0, 4'd0, "R6 status read");
        chk("R6 status", bus_rdata, 32'h0000_0003);
        // clear and pulse on the same source: flag stays
        step(1'b1, 1'b1, 3'd4, 1'b1, 1'b0, 32'h0000_0002, 4'b0010, "R6 clear vs pulse");
        step(1'b1, 1'b0, 3'd4, 1'b1, 1'b0, 32'd0, 4'd0, "R6 status after race");
        chk("R6 race", bus_rdata, 32'h0000_0003);
        step(1'b1, 1'b1, 3'd4, 1'b1, 1'b0, 32'hFFFF_FFFF, 4'd0, "R6 clear all");
        idle();
        chk("R7 released", {31'd0, irq_norm_n}, 32'd1);

        // R9: refused user access
        step(1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 32'hFFFF_FFFF, 4'd0, "R9 refused write");
        step(1'b1, 1'b0, 3'd4, 1'b0, 1'b0, 32'd0, 4'd0, "R9 refused read keeps rdata");
        step(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 32'd0, 4'd0, "R9 user read allowed");
        chk("R9 mask intact", bus_rdata, 32'h8000_0006);

        // R10: unmapped addresses
        step(1'b1, 1'b1, 3'd5, 1'b1, 1'b0, 32'hFFFF_FFFF, 4'd0, "R10 unmapped write");
        step(1'b1, 1'b0, 3'd6, 1'b1, 1'b0, 32'd0, 4'd0, "R10 unmapped read");
        step(1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 32'd0, 4'd0, "R10 masks untouched");
        chk("R10 value", bus_rdata, 32'h8000_0006);

        // Seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            logic [31:0] wd;
            logic [3:0]  p;
            logic [2:0]  a;
            string       tag;
            r  = $urandom;
            wd = $urandom;
            a  = r[2:0];
            p  = (r[7:5] == 3'd0) ? r[11:8] : 4'd0;
            if (a >= 3'd5)      tag = "R10 random";
            else if (a == 3'd4) tag = "R6 random";
            else                tag = "R5 random";
            step(r[12] | r[13], r[14], a, r[15] | r[16], r[17], wd, p, tag);
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule